// File: doc/BRIEF.md
# DRAM Controller with Row/Column Multiplexing and Timed Refresh

This block sits between a simple host request port and a DRAM device whose address pins are shared between the row and the column. The host presents a full word address, a read or write flag and write data. The controller takes the request only while `req_ready` is high. It then drives the row half of the address under an active-low row strobe, and after that the column half under an active-low column strobe. For a read, it returns the word with a one-cycle valid pulse. A precharge gap, with both strobes high, closes every operation.

An internal interval timer raises a pending-refresh flag at a fixed period. The controller serves that flag before it accepts any new host request, but it never cuts short an access that is already running. Each refresh is row-only: the row strobe drops with the value of the refresh row counter on the address pins, the column strobe stays high, and the counter then advances and wraps at the number of rows. A two-bit status output tells the system whether the controller is idle, serving the host, or refreshing.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `status` is 2'b00, `ras_n`, `cas_n` and `we_n` are 1, `dq_oe` is 0 and `rd_valid` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. For the next T_RC cycles, `ras_n` is 0, `cas_n` is 1 and `dram_addr` carries the row, which is `req_addr[ADDR_BITS-1:COL_BITS]`.
- R3: For the T_CD cycles after the row phase, `ras_n` and `cas_n` are both 0 and `dram_addr` carries the column, which is `req_addr[COL_BITS-1:0]`. The column strobe never falls unless the row strobe is already low.
- R4: For a read, `rd_valid` is high for exactly one cycle: the cycle after the last column cycle. In that cycle, `rd_data` holds the word last written to that address (zero if the address was never written).
- R5: After the column phase, or after the row phase of a refresh, both strobes stay high for T_PRE cycles. The controller then returns to idle.
- R6: The refresh timer counts clock cycles from reset. It sets the pending flag at the edge that ends every REF_INTERVAL-th cycle.
- R7: While a refresh is pending in idle, `req_ready` is 0, and the next operation is a refresh. An access already in progress runs to completion first.
- R8: A refresh holds `ras_n` at 0 and `cas_n` at 1 for T_RC cycles, with the refresh counter on `dram_addr`. The counter starts at 0 and advances by one per refresh, wrapping at 2^ROW_BITS.
- R9: `status` is 2'b00 when idle, 2'b01 from host acceptance to the end of its precharge, and 2'b10 from refresh start to the end of its precharge. The value 2'b11 never appears.
- R10: `req_ready` is high only in idle. A request held while `req_ready` is low causes no strobe activity until it is accepted.
- R11: `dq_oe` is 1, `we_n` is 0 and `dq_out` holds the write data only during the column phase of a write. Otherwise `dq_oe` is 0 and the data pins are left to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in the upper bits |
| req_wdata | input | DATA_BITS | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse: read data valid |
| rd_data | output | DATA_BITS | Read data |
| status | output | 2 | 00 idle, 01 host access, 10 refresh |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | DATA_BITS | Data toward the device |
| dq_oe | output | 1 | Controller drives the data pins |
| dq_in | input | DATA_BITS | Data from the device |

## Verification
The two functions that can fall in the same cycle are timer expiry and host acceptance. The bench provokes this by waiting until its own timer model is one cycle from expiry and then presenting a request, so the edge that accepts the access also sets the pending flag. The host access must run unbroken, and the refresh must follow directly after its precharge with `req_ready` held low. Because of this, the behavioural model compares every strobe, the address, status and ready in every cycle of that window.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_BITS     = 4,
  parameter int COL_BITS     = 4,
  parameter int DATA_BITS    = 8,
  parameter int T_RC         = 2,
  parameter int T_CD         = 2,
  parameter int T_PRE        = 2,
  parameter int REF_INTERVAL = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ROW_BITS+COL_BITS-1:0]      req_addr,
  input  logic [DATA_BITS-1:0]              req_wdata,
  output logic                              req_ready,
  output logic                              rd_valid,
  output logic [DATA_BITS-1:0]              rd_data,
  output logic [1:0]                        status,
  output logic [((ROW_BITS>COL_BITS)?ROW_BITS:COL_BITS)-1:0] dram_addr,
  output logic                              ras_n,
  output logic                              cas_n,
  output logic                              we_n,
  output logic [DATA_BITS-1:0]              dq_out,
  output logic                              dq_oe,
  input  logic [DATA_BITS-1:0]              dq_in
);
  localparam int ADDR_BITS = ROW_BITS + COL_BITS;
  localparam int BUS_BITS  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int STEP_BITS = $clog2(T_RC + T_CD + T_PRE + 1);
  localparam int TMR_BITS  = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} state_t;

  state_t                 state;
  logic [STEP_BITS-1:0]   step;
  logic [TMR_BITS-1:0]    timer;
  logic                   pend, in_ref, is_wr;
  logic [ROW_BITS-1:0]    row_q, ref_row;
  logic [COL_BITS-1:0]    col_q;
  logic [DATA_BITS-1:0]   wdata_q;
  int                     lim;
  logic                   done, tick;

  always_comb begin
    case (state)
      S_ROW, S_REF: lim = T_RC;
      S_COL:        lim = T_CD;
      S_PRE:        lim = T_PRE;
      default:      lim = 1;
    endcase
  end

  assign done = (step == STEP_BITS'(lim - 1));
  assign tick = (timer == TMR_BITS'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= '0;
      timer    <= '0;
      pend     <= 1'b0;
      in_ref   <= 1'b0;
      is_wr    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      ref_row  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      timer    <= tick ? '0 : timer + 1'b1;
      if (tick)
        pend <= 1'b1;
      else if (state == S_IDLE && pend)
        pend <= 1'b0;
      case (state)
        S_IDLE: begin
          step <= '0;
          if (pend) begin
            state  <= S_REF;
            in_ref <= 1'b1;
          end else if (req_valid) begin
            state   <= S_ROW;
            in_ref  <= 1'b0;
            is_wr   <= req_write;
            row_q   <= req_addr[ADDR_BITS-1:COL_BITS];
            col_q   <= req_addr[COL_BITS-1:0];
            wdata_q <= req_wdata;
          end
        end
        S_ROW: begin
          step <= done ? '0 : step + 1'b1;
          if (done) state <= S_COL;
        end
        S_COL: begin
          step <= done ? '0 : step + 1'b1;
          if (done) begin
            state <= S_PRE;
            if (!is_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dq_in;
            end
          end
        end
        S_REF: begin
          step <= done ? '0 : step + 1'b1;
          if (done) begin
            state   <= S_PRE;
            ref_row <= ref_row + 1'b1;
          end
        end
        S_PRE: begin
          step <= done ? '0 : step + 1'b1;
          if (done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE) && !pend;
  assign ras_n     = !(state == S_ROW || state == S_COL || state == S_REF);
  assign cas_n     = (state != S_COL);
  assign we_n      = !(state == S_COL && is_wr);
  assign dq_oe     = (state == S_COL) && is_wr;
  assign dq_out    = wdata_q;
  assign status    = (state == S_IDLE) ? 2'b00 : (in_ref ? 2'b10 : 2'b01);
  assign dram_addr = (state == S_COL) ? BUS_BITS'(col_q)
                   : (state == S_REF) ? BUS_BITS'(ref_row)
                   : BUS_BITS'(row_q);
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 rd_valid,
  input logic [1:0]           status,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 dq_oe
);
  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R3
  AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> $past(!ras_n)); // R2
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R4
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (ras_n && cas_n && status == 2'b00)); // R10
  AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (!cas_n && !we_n)); // R11
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n) status != 2'b11); // R9
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n) status == 2'b10 |-> cas_n); // R8
endmodule

bind dram_ctrl dram_ctrl_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .status(status), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe)
);

// File: tb/dram_ctrl_test.sv
`timescale 1ns/1ps
module dram_ctrl_test;
  localparam int RB = 4, CB = 4, DB = 8;
  localparam int TRC = 2, TCD = 2, TPRE = 2, INTV = 64;
  localparam int NR = 1 << RB;
  localparam int AB = RB + CB;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AB-1:0] req_addr = '0;
  logic [DB-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DB-1:0] rd_data, dq_out, dq_in;
  logic [1:0] status;
  logic [RB-1:0] dram_addr;

  dram_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_BITS(DB), .T_RC(TRC), .T_CD(TCD),
              .T_PRE(TPRE), .REF_INTERVAL(INTV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .status(status), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in));

  always #2 clk = ~clk;

  // behavioural device: row latched on strobe fall, column on its own strobe
  logic [DB-1:0] dev_mem [NR*NR];
  int dev_row = 0;
  logic prev_ras = 1;
  initial for (int i = 0; i < NR*NR; i++) dev_mem[i] = '0;
  always @(posedge clk) begin
    if (!ras_n && prev_ras) dev_row = int'(dram_addr);
    if (!cas_n && !we_n) dev_mem[dev_row*NR + int'(dram_addr)] = dq_out;
    prev_ras = ras_n;
  end
  assign dq_in = (!cas_n && we_n) ? dev_mem[dev_row*NR + int'(dram_addr)] : 'z;

  // reference model
  int checks = 0, errors = 0;
  int mtimer, mop, mstep, mrefrow;
  bit mpend, mw, mrdv;
  int maddr, mwd, mrdexp;
  int mem [NR*NR];
  initial for (int i = 0; i < NR*NR; i++) mem[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mtimer = 0; mop = 0; mstep = 0; mrefrow = 0; mpend = 0; mw = 0; mrdv = 0;
      maddr = 0; mwd = 0; mrdexp = 0;
    end else begin
      bit fire;
      fire = (mtimer == INTV-1);
      mtimer = fire ? 0 : mtimer + 1;
      mrdv = 0;
      if (mop == 0) begin
        if (mpend) begin mop = 2; mstep = 0; mpend = 0; end
        else if (req_valid) begin
          mop = 1; mstep = 0; mw = req_write; maddr = int'(req_addr); mwd = int'(req_wdata);
          if (mw) mem[maddr] = mwd;
        end
      end else begin
        int last;
        last = (mop == 1) ? TRC+TCD+TPRE-1 : TRC+TPRE-1;
        if (mop == 1 && mstep == TRC+TCD-1 && !mw) begin mrdv = 1; mrdexp = mem[maddr]; end
        if (mstep == last) begin
          if (mop == 2) mrefrow = (mrefrow + 1) % NR;
          mop = 0;
        end else mstep++;
      end
      if (fire) mpend = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int eras, ecas, eaddr, est;
    bit ewr;
    eras = 1; ecas = 1; eaddr = 0; ewr = 0;
    if (mop == 1 && mstep < TRC) begin eras = 0; eaddr = maddr / NR; end
    else if (mop == 1 && mstep < TRC+TCD) begin eras = 0; ecas = 0; eaddr = maddr % NR; ewr = mw; end
    else if (mop == 2 && mstep < TRC) begin eras = 0; eaddr = mrefrow; end
    est = (mop == 0) ? 0 : (mop == 1 ? 1 : 2);
    if (mop == 1 && mstep < TRC) chk(ras_n == eras && cas_n == ecas, "R2", {ras_n, cas_n}, eras*2+ecas);
    else if (mop == 1 && mstep < TRC+TCD) chk(ras_n == eras && cas_n == ecas, "R3", {ras_n, cas_n}, eras*2+ecas);
    else if (mop == 2 && mstep < TRC) chk(ras_n == eras && cas_n == ecas, "R8", {ras_n, cas_n}, eras*2+ecas);
    else chk(ras_n == eras && cas_n == ecas, "R5", {ras_n, cas_n}, eras*2+ecas);
    if (eras == 0) chk(int'(dram_addr) == eaddr, (mop == 2) ? "R8" : (ecas == 0 ? "R3" : "R2"),
                       int'(dram_addr), eaddr);
    if (mop == 2 && mstep == 0) chk(status == 2'b10, "R6", status, 2);
    chk(int'(status) == est, "R9", status, est);
    chk(req_ready == (mop == 0 && !mpend), mpend ? "R7" : "R10", req_ready, (mop == 0 && !mpend));
    chk(dq_oe == ewr && we_n == !ewr, "R11", {dq_oe, we_n}, {ewr, !ewr});
    if (ewr) chk(int'(dq_out) == mwd, "R11", dq_out, mwd);
    chk(rd_valid == mrdv, "R4", rd_valid, mrdv);
    if (mrdv) chk(int'(rd_data) == mrdexp, "R4", rd_data, mrdexp);
  end

  task automatic issue(input bit w, input int a, input int d);
    bit ok;
    req_valid = 1; req_write = w; req_addr = AB'(a); req_wdata = DB'(d);
    do begin
      ok = req_ready;
      @(negedge clk);
    end while (!ok);
    req_valid = 0;
  endtask

  bit finished = 0;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1 && status == 2'b00, "R1", {req_ready, status}, 4);
    chk(ras_n && cas_n && we_n && !dq_oe && !rd_valid, "R1",
        {ras_n, cas_n, we_n, dq_oe, rd_valid}, 5'b11100);
    for (int i = 0; i < NR*NR; i += 17) issue(1, i, (i * 7 + 3) & 8'hff);
    for (int i = 0; i < NR*NR; i += 17) issue(0, i, 0);
    issue(0, 8'h21, 0); // never written: reads zero
    // collisions: request accepted in the cycle the timer expires (R7)
    for (int k = 0; k < 4; k++) begin
      while (!(mtimer == INTV-1 && mop == 0 && !mpend)) @(negedge clk);
      issue(k[0], 8'h40 + k, 8'h5a + k);
      repeat (12) @(negedge clk);
    end
    // mixed traffic long enough for refresh counter wrap (R8)
    begin
      int s = 12345;
      for (int n = 0; n < 400; n++) begin
        s = (s * 1103515245 + 12345) & 32'h7fffffff;
        issue(s[20], (s >> 4) & 8'hff, (s >> 12) & 8'hff);
        if (s[3]) repeat (s & 7) @(negedge clk);
      end
    end
    repeat (20) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule